// File: doc/BRIEF.md
# Two-Wire Serial Bus Controller Register Front End

This block is the software-visible register file that sits in front of a two-wire serial bus engine. A host reaches it through a plain 32-bit port with a 4-bit word address. Writes take effect on the clock edge. Reads are combinational from the addressed word. The block keeps the transfer parameters for the engine: command code, register address, write data, runtime and hardware device addresses, clock divider and output delay, device-mode pattern and manual line levels. It presents these to the engine continuously.

The engine handshake is limited to the following signals. The front end issues one-cycle start, abort and init-sequence pulses, and holds a reset level while a soft reset runs. The engine answers with a completion pulse, which may carry an error qualifier, an acknowledge-error flag and a per-byte error mask. It also answers with an init-done pulse and the received data. Completion events land in a write-one-to-clear status word. Each status event has an enable bit, and a global enable gates them all into one interrupt line. A start requested while a transfer is still running does not reach the engine. Instead it raises a load-busy flag.

Top module: `sbus_regfront`

## Requirements
- R1: After reset every register reads zero, `irq` is low and no engine pulse is active.
- R2: Writing 1 to control bit 7 while idle produces one `engStart` pulse in the cycle after the write. Control bit 7 reads 1 from that cycle until the engine's completion pulse. A completion without error sets status bit 0.
- R3: Writing 1 to control bit 7 while a transfer runs sets status bit 2, issues no `engStart`, and leaves the transfer running.
- R4: A completion with `engErr` high sets status bit 1. It also ORs `engByteErr` into status bits 8 upward, one per byte lane, and sets status bit 16 when `engAckErr` is high.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. When a clear and a new event for the same bit fall in one cycle, the event wins.
- R6: `irq` is control bit 1 ANDed with the OR, over status bits 0 to 2, of each status bit ANDed with the matching enable bit (interrupt-enable register bits 2:0).
- R7: On an error-free completion of a read command, the data word loads the received value with everything above the access width forced to zero. Command 0x8B reads 8 bits, 0x9C reads 16 bits and 0xA6 reads 32 bits. Other commands leave the data word as written.
- R8: Writing 1 to control bit 6 during a transfer issues one `engAbort` pulse and returns control bit 7 to 0. A completion pulse arriving afterwards sets no status. Bit 6 always reads 0, and abort while idle does nothing.
- R9: Writing 1 to control bit 0 returns all registers to their reset values. Control bit 0 and `engReset` then read 1 for RST_CYCLES cycles. Bus writes are ignored during that window.
- R10: Writing 1 to device-mode bit 31 issues one `engInit` pulse. Bit 31 reads 1 until `engInitDone`, and further writes of bit 31 meanwhile issue no pulse. Bits 23:0 are stored and drive `engModeCfg`.
- R11: Line-control bits 3:0 are stored and drive `lineCtl`. Bits 4 and 5 read the live `sdaIn` and `sclIn` levels.
- R12: Word addresses are: control 0, clock 1, interrupt enable 2, status 3, register address 4, data 7, line 9, device mode 10, command 11, device address 12. The clock word holds the divider in 7:0 and the delay in 10:8. The device-address word holds the runtime address in 23:16 and the hardware address in 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe for the addressed word |
| busAddr | input | 4 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data of the addressed word |
| engStart | output | 1 | One-cycle transfer start pulse |
| engAbort | output | 1 | One-cycle abort pulse |
| engInit | output | 1 | One-cycle init-sequence pulse |
| engReset | output | 1 | Engine reset level during soft reset |
| engDone | input | 1 | Transfer completion pulse |
| engErr | input | 1 | Completion carries an error |
| engAckErr | input | 1 | Error was a missing acknowledge |
| engByteErr | input | BYTE_LANES | Per-byte error mask |
| engInitDone | input | 1 | Init sequence sent |
| engRdData | input | 32 | Received data |
| engCmd | output | 8 | Command code |
| engRegAddr | output | 8 | Target register address |
| engWrData | output | 32 | Data word to send |
| engRtAddr | output | 8 | Runtime device address |
| engHwAddr | output | 16 | Hardware device address |
| engClkDiv | output | 8 | Clock divider |
| engSdaDelay | output | 3 | Data output delay |
| engModeCfg | output | 24 | Device-mode pattern |
| lineCtl | output | 4 | Manual line drive enables and levels |
| sdaIn | input | 1 | Live data line level |
| sclIn | input | 1 | Live clock line level |
| irq | output | 1 | Interrupt |

## Verification
The hardest case to reach is the collision, inside a single cycle, between a host clear of a status bit and a new completion event for the same bit. The bench leaves a first done flag set and starts a second transfer. It then drives the status clear write and the engine's completion pulse on the same clock edge, and checks that the flag survives. The load-busy path is reached in a similar way. A second start write is issued while the engine model withholds completion, which confirms both that the flag is raised and that no start pulse appears.

// File: rtl/sbus_regfront_pkg.sv
package sbus_regfront_pkg;

  localparam int ADDR_W = 4;
  localparam int BUS_W  = 32;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CLK   = 4'd1;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd2;
  localparam logic [ADDR_W-1:0] A_IST   = 4'd3;
  localparam logic [ADDR_W-1:0] A_RADDR = 4'd4;
  localparam logic [ADDR_W-1:0] A_DATA  = 4'd7;
  localparam logic [ADDR_W-1:0] A_LINE  = 4'd9;
  localparam logic [ADDR_W-1:0] A_DMODE = 4'd10;
  localparam logic [ADDR_W-1:0] A_CMD   = 4'd11;
  localparam logic [ADDR_W-1:0] A_DEV   = 4'd12;

  localparam logic [7:0] CMD_RD_BYTE = 8'h8B;
  localparam logic [7:0] CMD_RD_HALF = 8'h9C;
  localparam logic [7:0] CMD_RD_WORD = 8'hA6;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadBusy;
    logic softRst;
    logic xferDone;
    logic xferFail;
  } ctlStrobes_t;

  function automatic logic isReadCmd(input logic [7:0] code);
    return (code == CMD_RD_BYTE) || (code == CMD_RD_HALF) || (code == CMD_RD_WORD);
  endfunction

  function automatic logic [BUS_W-1:0] readMask(input logic [7:0] code);
    case (code)
      CMD_RD_BYTE: return 32'h0000_00FF;
      CMD_RD_HALF: return 32'h0000_FFFF;
      CMD_RD_WORD: return 32'hFFFF_FFFF;
      default:     return '0;
    endcase
  endfunction

endpackage

// File: rtl/sbus_regfront_ctl.sv
module sbus_regfront_ctl
  import sbus_regfront_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              bitStart,
  input  logic              bitAbort,
  input  logic              bitReset,
  input  logic              bitInit,
  input  logic              engDone,
  input  logic              engErr,
  input  logic              engInitDone,
  output ctlStrobes_t       strb,
  output logic              busy,
  output logic              initPending,
  output logic              rstActive,
  output logic              engStart,
  output logic              engAbort,
  output logic              engInit,
  output logic              engReset
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] rstCnt;
  logic ctrlWr, dmodeWr;
  logic startGo, abortGo, initGo;

  assign rstActive = (rstCnt != '0);
  assign ctrlWr    = busWrite && (busAddr == A_CTRL) && !rstActive;
  assign dmodeWr   = busWrite && (busAddr == A_DMODE) && !rstActive;

  always_comb begin
    strb    = '0;
    startGo = 1'b0;
    abortGo = 1'b0;
    initGo  = 1'b0;
    if (ctrlWr && bitReset) begin
      strb.softRst = 1'b1;
    end else begin
      abortGo       = ctrlWr && bitAbort && busy;
      startGo       = ctrlWr && bitStart && !busy;
      strb.loadBusy = ctrlWr && bitStart && busy && !bitAbort;
      strb.xferDone = busy && engDone && !engErr && !abortGo;
      strb.xferFail = busy && engDone && engErr && !abortGo;
      initGo        = dmodeWr && bitInit && !initPending;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (strb.softRst || abortGo) begin
      busy <= 1'b0;
    end else if (startGo) begin
      busy <= 1'b1;
    end else if (strb.xferDone || strb.xferFail) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initPending <= 1'b0;
    end else if (strb.softRst) begin
      initPending <= 1'b0;
    end else if (initGo) begin
      initPending <= 1'b1;
    end else if (engInitDone) begin
      initPending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt <= '0;
    end else if (strb.softRst) begin
      rstCnt <= CNT_W'(RST_CYCLES);
    end else if (rstActive) begin
      rstCnt <= rstCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engStart <= 1'b0;
      engAbort <= 1'b0;
      engInit  <= 1'b0;
    end else begin
      engStart <= startGo;
      engAbort <= abortGo;
      engInit  <= initGo;
    end
  end

  assign engReset = rstActive;

  // R2: a start pulse is only seen with the transfer marked running
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> busy);

  // R3: a start request while running never restarts the engine
  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBusy |=> !engStart && busy);

  // R8: an abort leaves the block idle
  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    engAbort |-> !busy);

  // R9: soft reset leaves reset active and no transfer running
  assert_softrst_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> rstActive && !busy && !initPending);

  // R10: init pulse only while the sequence is pending
  assert_init_pending_R10: assert property (@(posedge clk) disable iff (!rstN)
    engInit |-> initPending);

endmodule

// File: rtl/sbus_regfront_dpath.sv
module sbus_regfront_dpath
  import sbus_regfront_pkg::*;
#(
  parameter int BYTE_LANES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrite,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [BUS_W-1:0]      busWdata,
  output logic [BUS_W-1:0]      busRdata,
  input  ctlStrobes_t           strb,
  input  logic                  busy,
  input  logic                  initPending,
  input  logic                  rstActive,
  input  logic                  engAckErr,
  input  logic [BYTE_LANES-1:0] engByteErr,
  input  logic [BUS_W-1:0]      engRdData,
  input  logic                  sdaIn,
  input  logic                  sclIn,
  output logic [7:0]            engCmd,
  output logic [7:0]            engRegAddr,
  output logic [BUS_W-1:0]      engWrData,
  output logic [7:0]            engRtAddr,
  output logic [15:0]           engHwAddr,
  output logic [7:0]            engClkDiv,
  output logic [2:0]            engSdaDelay,
  output logic [23:0]           engModeCfg,
  output logic [3:0]            lineCtl,
  output logic                  irq
);

  localparam int ERR_LSB = 8;
  localparam int ACK_BIT = 16;

  typedef struct packed {
    logic             gie;
    logic [7:0]       clkDiv;
    logic [2:0]       sdaDly;
    logic [2:0]       ien;
    logic [7:0]       regAddr;
    logic [BUS_W-1:0] data;
    logic [3:0]       line;
    logic [23:0]      mode;
    logic [7:0]       cmd;
    logic [7:0]       rt;
    logic [15:0]      hw;
  } cfgRegs_t;

  typedef struct packed {
    logic                  ack;
    logic [BYTE_LANES-1:0] byteErr;
    logic                  lb;
    logic                  fail;
    logic                  done;
  } statRegs_t;

  cfgRegs_t  cfgQ, cfgD;
  statRegs_t stQ, stD;
  logic      wrEn, istWr;

  assign wrEn  = busWrite && !rstActive && !strb.softRst;
  assign istWr = wrEn && (busAddr == A_IST);

  always_comb begin
    cfgD = cfgQ;
    if (wrEn) begin
      case (busAddr)
        A_CTRL:  cfgD.gie = busWdata[1];
        A_CLK: begin
          cfgD.clkDiv = busWdata[7:0];
          cfgD.sdaDly = busWdata[10:8];
        end
        A_IEN:   cfgD.ien = busWdata[2:0];
        A_RADDR: cfgD.regAddr = busWdata[7:0];
        A_DATA:  cfgD.data = busWdata;
        A_LINE:  cfgD.line = busWdata[3:0];
        A_DMODE: cfgD.mode = busWdata[23:0];
        A_CMD:   cfgD.cmd = busWdata[7:0];
        A_DEV: begin
          cfgD.rt = busWdata[23:16];
          cfgD.hw = busWdata[15:0];
        end
        default: ;
      endcase
    end
    if (strb.xferDone && isReadCmd(cfgQ.cmd)) begin
      cfgD.data = engRdData & readMask(cfgQ.cmd);
    end
  end

  always_comb begin
    stD = stQ;
    if (istWr) begin
      stD.done    = stQ.done & ~busWdata[0];
      stD.fail    = stQ.fail & ~busWdata[1];
      stD.lb      = stQ.lb & ~busWdata[2];
      stD.byteErr = stQ.byteErr & ~busWdata[ERR_LSB +: BYTE_LANES];
      stD.ack     = stQ.ack & ~busWdata[ACK_BIT];
    end
    // Events win over clears
    stD.done = stD.done | strb.xferDone;
    stD.lb   = stD.lb | strb.loadBusy;
    if (strb.xferFail) begin
      stD.fail    = 1'b1;
      stD.ack     = stD.ack | engAckErr;
      stD.byteErr = stD.byteErr | engByteErr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
      stQ  <= '0;
    end else if (strb.softRst) begin
      cfgQ <= '0;
      stQ  <= '0;
    end else begin
      cfgQ <= cfgD;
      stQ  <= stD;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_CTRL: begin
        busRdata[7] = busy;
        busRdata[1] = cfgQ.gie;
        busRdata[0] = rstActive;
      end
      A_CLK: begin
        busRdata[7:0]  = cfgQ.clkDiv;
        busRdata[10:8] = cfgQ.sdaDly;
      end
      A_IEN:   busRdata[2:0] = cfgQ.ien;
      A_IST: begin
        busRdata[0] = stQ.done;
        busRdata[1] = stQ.fail;
        busRdata[2] = stQ.lb;
        busRdata[ERR_LSB +: BYTE_LANES] = stQ.byteErr;
        busRdata[ACK_BIT] = stQ.ack;
      end
      A_RADDR: busRdata[7:0] = cfgQ.regAddr;
      A_DATA:  busRdata = cfgQ.data;
      A_LINE:  busRdata[5:0] = {sclIn, sdaIn, cfgQ.line};
      A_DMODE: busRdata = {initPending, 7'd0, cfgQ.mode};
      A_CMD:   busRdata[7:0] = cfgQ.cmd;
      A_DEV:   busRdata[23:0] = {cfgQ.rt, cfgQ.hw};
      default: ;
    endcase
  end

  assign irq = cfgQ.gie && |(cfgQ.ien & {stQ.lb, stQ.fail, stQ.done});

  assign engCmd      = cfgQ.cmd;
  assign engRegAddr  = cfgQ.regAddr;
  assign engWrData   = cfgQ.data;
  assign engRtAddr   = cfgQ.rt;
  assign engHwAddr   = cfgQ.hw;
  assign engClkDiv   = cfgQ.clkDiv;
  assign engSdaDelay = cfgQ.sdaDly;
  assign engModeCfg  = cfgQ.mode;
  assign lineCtl     = cfgQ.line;

  // R5: a clear of the done flag with no new event leaves it low
  assert_w1c_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    istWr && busWdata[0] && !strb.xferDone |=> !stQ.done);

  // R5: an event in the same cycle as a clear still sets the flag
  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.xferFail |=> stQ.fail);

  // R7: data captured from a read is zero above the access width
  assert_zero_ext_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.xferDone && isReadCmd(cfgQ.cmd) |=> (cfgQ.data & ~readMask($past(cfgQ.cmd))) == '0);

  // R9: writes are ignored while the soft reset runs
  assert_rst_ignores_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstActive && !strb.softRst |=> $stable(cfgQ));

endmodule

// File: rtl/sbus_regfront.sv
module sbus_regfront
  import sbus_regfront_pkg::*;
#(
  parameter int RST_CYCLES = 4,
  parameter int BYTE_LANES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrite,
  input  logic [3:0]            busAddr,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  output logic                  engStart,
  output logic                  engAbort,
  output logic                  engInit,
  output logic                  engReset,
  input  logic                  engDone,
  input  logic                  engErr,
  input  logic                  engAckErr,
  input  logic [BYTE_LANES-1:0] engByteErr,
  input  logic                  engInitDone,
  input  logic [31:0]           engRdData,
  output logic [7:0]            engCmd,
  output logic [7:0]            engRegAddr,
  output logic [31:0]           engWrData,
  output logic [7:0]            engRtAddr,
  output logic [15:0]           engHwAddr,
  output logic [7:0]            engClkDiv,
  output logic [2:0]            engSdaDelay,
  output logic [23:0]           engModeCfg,
  output logic [3:0]            lineCtl,
  input  logic                  sdaIn,
  input  logic                  sclIn,
  output logic                  irq
);

  ctlStrobes_t strb;
  logic busy, initPending, rstActive;

  sbus_regfront_ctl #(.RST_CYCLES(RST_CYCLES)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .busWrite    (busWrite),
    .busAddr     (busAddr),
    .bitStart    (busWdata[7]),
    .bitAbort    (busWdata[6]),
    .bitReset    (busWdata[0]),
    .bitInit     (busWdata[31]),
    .engDone     (engDone),
    .engErr      (engErr),
    .engInitDone (engInitDone),
    .strb        (strb),
    .busy        (busy),
    .initPending (initPending),
    .rstActive   (rstActive),
    .engStart    (engStart),
    .engAbort    (engAbort),
    .engInit     (engInit),
    .engReset    (engReset)
  );

  sbus_regfront_dpath #(.BYTE_LANES(BYTE_LANES)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .busWrite    (busWrite),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .strb        (strb),
    .busy        (busy),
    .initPending (initPending),
    .rstActive   (rstActive),
    .engAckErr   (engAckErr),
    .engByteErr  (engByteErr),
    .engRdData   (engRdData),
    .sdaIn       (sdaIn),
    .sclIn       (sclIn),
    .engCmd      (engCmd),
    .engRegAddr  (engRegAddr),
    .engWrData   (engWrData),
    .engRtAddr   (engRtAddr),
    .engHwAddr   (engHwAddr),
    .engClkDiv   (engClkDiv),
    .engSdaDelay (engSdaDelay),
    .engModeCfg  (engModeCfg),
    .lineCtl     (lineCtl),
    .irq         (irq)
  );

endmodule

// File: tb/sbus_regfront_bench.sv
module sbus_regfront_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        engStart, engAbort, engInit, engReset;
  logic        engDone = 1'b0, engErr = 1'b0, engAckErr = 1'b0, engInitDone = 1'b0;
  logic [3:0]  engByteErr = '0;
  logic [31:0] engRdData = '0;
  logic [7:0]  engCmd, engRegAddr, engRtAddr, engClkDiv;
  logic [31:0] engWrData;
  logic [15:0] engHwAddr;
  logic [2:0]  engSdaDelay;
  logic [23:0] engModeCfg;
  logic [3:0]  lineCtl;
  logic        sdaIn = 1'b0, sclIn = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sbus_regfront u_sbus_regfront (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .engStart(engStart),
    .engAbort(engAbort), .engInit(engInit), .engReset(engReset),
    .engDone(engDone), .engErr(engErr), .engAckErr(engAckErr),
    .engByteErr(engByteErr), .engInitDone(engInitDone), .engRdData(engRdData),
    .engCmd(engCmd), .engRegAddr(engRegAddr), .engWrData(engWrData),
    .engRtAddr(engRtAddr), .engHwAddr(engHwAddr), .engClkDiv(engClkDiv),
    .engSdaDelay(engSdaDelay), .engModeCfg(engModeCfg), .lineCtl(lineCtl),
    .sdaIn(sdaIn), .sclIn(sclIn), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic finishXfer(input logic err, input logic ack, input logic [3:0] bytes,
                            input logic [31:0] rdata);
    @(negedge clk);
    engDone = 1'b1; engErr = err; engAckErr = ack; engByteErr = bytes; engRdData = rdata;
    @(negedge clk);
    engDone = 1'b0; engErr = 1'b0; engAckErr = 1'b0; engByteErr = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'd0, v);  chk("R1 ctrl", v, 0);
    rd(4'd1, v);  chk("R1 clk", v, 0);
    rd(4'd3, v);  chk("R1 status", v, 0);
    rd(4'd7, v);  chk("R1 data", v, 0);
    chk("R1 irq/start", {irq, engStart, engInit}, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(4'd1, 32'h0000_05AB);
    chk("R12 clkdiv", engClkDiv, 8'hAB);
    chk("R12 delay", engSdaDelay, 3'd5);
    rd(4'd1, v); chk("R12 clk read", v, 32'h5AB);
    wr(4'd12, 32'hFF2D_03A3);
    chk("R12 rt/hw", {engRtAddr, engHwAddr}, {8'h2D, 16'h03A3});
    rd(4'd12, v); chk("R12 dev read", v, 32'h002D_03A3);
    wr(4'd4, 32'h0000_1234);
    rd(4'd4, v); chk("R12 raddr", v, 32'h34);
  endtask

  task automatic t_start();
    logic [31:0] v;
    wr(4'd11, 32'h4E);
    wr(4'd7, 32'h55);
    wr(4'd0, 32'h80);
    chk("R2 start pulse", engStart, 1);
    rd(4'd0, v); chk("R2 busy bit", v[7], 1);
    @(negedge clk);
    chk("R2 pulse one cycle", engStart, 0);
    finishXfer(0, 0, 0, 32'hDEAD_BEEF);
    rd(4'd3, v); chk("R2 done flag", v, 32'h1);
    rd(4'd0, v); chk("R2 idle", v[7], 0);
    rd(4'd7, v); chk("R7 write cmd keeps data", v, 32'h55);
    wr(4'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_loadbusy();
    logic [31:0] v;
    wr(4'd0, 32'h80);
    wr(4'd0, 32'h80);
    chk("R3 no restart", engStart, 0);
    rd(4'd3, v); chk("R3 load busy", v, 32'h4);
    rd(4'd0, v); chk("R3 still busy", v[7], 1);
    finishXfer(0, 0, 0, 0);
    rd(4'd3, v); chk("R3 then done", v, 32'h5);
    wr(4'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_error();
    logic [31:0] v;
    wr(4'd0, 32'h80);
    finishXfer(1, 1, 4'b0100, 0);
    rd(4'd3, v); chk("R4 error fields", v, 32'h0001_0402);
    wr(4'd3, 32'h2);
    rd(4'd3, v); chk("R5 partial clear", v, 32'h0001_0400);
    wr(4'd3, 32'h0001_0400);
    rd(4'd3, v); chk("R5 full clear", v, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(4'd0, 32'h80);
    finishXfer(0, 0, 0, 0);
    wr(4'd0, 32'h80);
    @(negedge clk);
    busWrite = 1'b1; busAddr = 4'd3; busWdata = 32'h1; engDone = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; engDone = 1'b0;
    rd(4'd3, v); chk("R5 event wins", v, 32'h1);
    wr(4'd3, 32'h1);
  endtask

  task automatic t_irq();
    wr(4'd2, 32'h1);
    wr(4'd0, 32'h82);
    chk("R6 no irq while running", irq, 0);
    finishXfer(0, 0, 0, 0);
    chk("R6 irq on done", irq, 1);
    wr(4'd0, 32'h0);
    chk("R6 gated by global", irq, 0);
    wr(4'd0, 32'h2);
    chk("R6 regated", irq, 1);
    wr(4'd2, 32'h2);
    chk("R6 masked by enable", irq, 0);
    wr(4'd3, 32'h1);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    wr(4'd11, 32'h8B); wr(4'd0, 32'h80);
    finishXfer(0, 0, 0, 32'hDEAD_BEEF);
    rd(4'd7, v); chk("R7 byte read", v, 32'hEF);
    wr(4'd11, 32'h9C); wr(4'd0, 32'h80);
    finishXfer(0, 0, 0, 32'hDEAD_BEEF);
    rd(4'd7, v); chk("R7 half read", v, 32'hBEEF);
    wr(4'd11, 32'hA6); wr(4'd0, 32'h80);
    finishXfer(0, 0, 0, 32'hCAFE_F00D);
    rd(4'd7, v); chk("R7 word read", v, 32'hCAFE_F00D);
    wr(4'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    wr(4'd0, 32'h80);
    wr(4'd0, 32'h40);
    chk("R8 abort pulse", engAbort, 1);
    rd(4'd0, v); chk("R8 idle after abort", v[7:6], 2'b00);
    finishXfer(0, 0, 0, 0);
    rd(4'd3, v); chk("R8 late done ignored", v, 32'h0);
    wr(4'd0, 32'h40);
    chk("R8 idle abort no pulse", engAbort, 0);
  endtask

  task automatic t_softrst();
    logic [31:0] v;
    wr(4'd1, 32'h3FF);
    wr(4'd0, 32'h01);
    chk("R9 engine reset", engReset, 1);
    rd(4'd0, v); chk("R9 reset bit", v[0], 1);
    rd(4'd1, v); chk("R9 clk restored", v, 0);
    wr(4'd1, 32'h77);
    rd(4'd1, v); chk("R9 write ignored", v, 0);
    repeat (5) @(negedge clk);
    rd(4'd0, v); chk("R9 reset done", v[0], 0);
    chk("R9 engine reset low", engReset, 0);
    wr(4'd1, 32'h77);
    rd(4'd1, v); chk("R9 writes resume", v, 32'h77);
  endtask

  task automatic t_init();
    logic [31:0] v;
    wr(4'd10, 32'h807C_3E00);
    chk("R10 init pulse", engInit, 1);
    chk("R10 mode cfg", engModeCfg, 24'h7C3E00);
    rd(4'd10, v); chk("R10 pending", v, 32'h807C_3E00);
    wr(4'd10, 32'h807C_3E00);
    chk("R10 no second pulse", engInit, 0);
    @(negedge clk); engInitDone = 1'b1;
    @(negedge clk); engInitDone = 1'b0;
    rd(4'd10, v); chk("R10 cleared", v, 32'h007C_3E00);
  endtask

  task automatic t_line();
    logic [31:0] v;
    wr(4'd9, 32'hF);
    chk("R11 drive", lineCtl, 4'hF);
    sdaIn = 1'b1; sclIn = 1'b0;
    rd(4'd9, v); chk("R11 sda live", v, 32'h1F);
    sdaIn = 1'b0; sclIn = 1'b1;
    rd(4'd9, v); chk("R11 scl live", v, 32'h2F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_start();
    t_loadbusy();
    t_error();
    t_collide();
    t_irq();
    t_read();
    t_abort();
    t_softrst();
    t_init();
    t_line();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule